// File: doc/BRIEF.md
# Synchronous Programming Link Master

This block is the host end of a two-wire synchronous serial link used to program a small microcontroller. It generates the link clock from the system clock through a programmable divider. It owns one shared data line, which it drives or releases as the direction changes, and it drives an active-low reset line towards the target. Every transfer is a 12-bit character: a low start bit, eight data bits sent least significant first, an even parity bit, and two high stop bits.

Software or a sequencer above the block issues byte-level commands over a valid/ready handshake. The five commands are: open the link, close the link, send a byte, receive a byte, and emit a break. A break is one full character time with the line held high. Opening the link holds the target in reset, parks the data line high, starts the clock, and emits two breaks back to back so that the target sees more than sixteen idle bits. A received byte comes back with its framing removed and a flag that reports a parity mismatch.

Top module: `prog_link_master`

## Requirements
- R1: A sent character is 12 bits on `data_out`, read at rising link-clock edges. Bit 0 is a start bit at 0, bits 1..8 carry the byte least significant bit first, bit 9 is parity, and bits 10 and 11 are stop bits at 1.
- R2: The parity bit makes the count of ones across the eight data bits and the parity bit even.
- R3: While transmitting, `data_out` changes only in the cycle in which `link_clk` falls.
- R4: A receive samples `data_in` only at rising link-clock edges. Edges that read high before the start bit are skipped, and the character begins at the first rising edge that reads low.
- R5: When the second stop bit is sampled, `rx_valid` pulses for one cycle with the byte on `rx_data`. `parity_error` is 1 exactly when the eight data bits and the received parity bit hold an odd number of ones.
- R6: A break (`cmd_op`=2) keeps `data_oe`=1 and `data_out`=1 at every rising edge while it is busy, for at least 12 edges.
- R7: Open (`cmd_op`=3) makes `tgt_rst_oe`=1 with `tgt_rst_n`=0, and makes `data_oe`=1 with `data_out`=1. It starts the clock and stays busy for at least 24 rising edges that all read high.
- R8: Receive (`cmd_op`=1) releases the data line (`data_oe`=0) only once the previous character has fully shifted out. The line stays released until the next send or break.
- R9: Close (`cmd_op`=4) sets `link_clk_oe`, `data_oe` and `tgt_rst_oe` to 0, and `link_clk` rests at 0.
- R10: `cmd_ready` is low while `busy` is high. An accepted send (`cmd_op`=0) makes the block busy on the next cycle.
- R11: Send, receive and break commands given while the link is closed are dropped. No line is driven and the clock does not start.
- R12: Each link-clock half period lasts `half_div` system cycles, with 0 treated as 1.
- R13: After reset the link is closed, no line is driven, `busy`=0 and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | DIV_W | Link-clock half period in system cycles |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 send, 1 receive, 2 break, 3 open, 4 close |
| cmd_data | input | 8 | Byte to send |
| cmd_ready | output | 1 | Command can be taken this cycle |
| busy | output | 1 | Character or open sequence in progress |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| parity_error | output | 1 | Parity mismatch of the last received byte |
| link_clk | output | 1 | Link clock level |
| link_clk_oe | output | 1 | Link clock driven |
| data_out | output | 1 | Data line level when driven |
| data_oe | output | 1 | Data line driven |
| data_in | input | 1 | Data line as seen at the pin |
| tgt_rst_n | output | 1 | Target reset level (low = held) |
| tgt_rst_oe | output | 1 | Target reset driven |

## Verification
The send path is swept over all 256 byte values. Each captured character is compared with a frame built arithmetically, which separates bit-order faults from parity faults. The receive path is swept over all 256 bytes with a varying count of idle-high edges before the start bit, which exposes early framing. A further set of bytes carries a deliberately wrong parity bit to show that the flag is not stuck. Separate runs at two divider settings measure the half period and watch the data-line changes against the clock edges. Commands sent while the link is closed, and the close sequence, are checked at the pins.

// File: rtl/plm_pkg.sv
// Shared types and helpers for the programming link master.
// Assumes a fixed 12-bit character: start, 8 data, parity, 2 stops.
package plm_pkg;
    localparam int FRAME_BITS = 12;

    typedef enum logic [2:0] {
        OP_SEND    = 3'd0,
        OP_RECV    = 3'd1,
        OP_BREAK   = 3'd2,
        OP_ENABLE  = 3'd3,
        OP_DISABLE = 3'd4
    } plm_op_e;

    // Builds the transmit character, bit 0 first on the wire.
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
        return {2'b11, ^d, d, 1'b0};
    endfunction
endpackage

// File: rtl/plm_clkgen.sv
// Link clock generator: divides the system clock so that each level lasts
// half_div cycles (0 acts as 1). It raises a one-cycle tick in the cycle
// before each toggle, split into rise and fall ticks.
// Assumes the clock rests low whenever run is low.
module plm_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             tick;

    // Effective half period, never below one cycle.
    always_comb lim = (half_div == '0) ? DIV_W'(1) : half_div;

    // End-of-half-period strobe and its edge direction.
    always_comb begin
        tick      = run && (cnt == lim - DIV_W'(1));
        rise_tick = tick && !sclk;
        fall_tick = tick && sclk;
    end

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/plm_shifter.sv
// Character shifter for the shared data line. Transmit shifts one bit out
// on each fall tick and completes at the rise tick after the last bit.
// Receive waits for a low bit on a rise tick, then takes the remaining 11
// bits and reports data and parity.
// Assumes start_tx and start_rx come only while idle.
module plm_shifter
    import plm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  start_tx,
    input  logic [FRAME_BITS-1:0] tx_frame,
    input  logic                  start_rx,
    input  logic                  sdi,
    output logic                  sdo,
    output logic                  released,
    output logic                  active,
    output logic                  tx_done,
    output logic                  rx_valid,
    output logic [7:0]            rx_data,
    output logic                  rx_perr
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(FRAME_BITS - 2);

    typedef enum logic [2:0] {S_IDLE, S_TX, S_TXEND, S_RXWAIT, S_RX} st_e;

    st_e                   st;
    logic [FRAME_BITS-1:0] sh;
    logic [FRAME_BITS-1:0] rx_next;
    logic [CNT_W-1:0]      bcnt;

    // Shift register value after taking the current input bit.
    always_comb rx_next = {sdi, sh[FRAME_BITS-1:1]};

    // Busy whenever a character is in flight or awaited.
    always_comb active = (st != S_IDLE);

    // Character state machine, shift register and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            sh       <= '1;
            bcnt     <= '0;
            sdo      <= 1'b1;
            released <= 1'b0;
            tx_done  <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
        end else begin
            tx_done  <= 1'b0;
            rx_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_tx) begin
                        sh       <= tx_frame;
                        bcnt     <= '0;
                        released <= 1'b0;
                        st       <= S_TX;
                    end else if (start_rx) begin
                        released <= 1'b1;
                        st       <= S_RXWAIT;
                    end
                end
                S_TX: begin
                    if (fall_tick) begin
                        sdo  <= sh[0];
                        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
                        bcnt <= bcnt + CNT_W'(1);
                        if (bcnt == LAST_TX) st <= S_TXEND;
                    end
                end
                S_TXEND: begin
                    if (rise_tick) begin
                        tx_done <= 1'b1;
                        st      <= S_IDLE;
                    end
                end
                S_RXWAIT: begin
                    if (rise_tick && !sdi) begin
                        bcnt <= '0;
                        st   <= S_RX;
                    end
                end
                S_RX: begin
                    if (rise_tick) begin
                        sh   <= rx_next;
                        bcnt <= bcnt + CNT_W'(1);
                        if (bcnt == LAST_RX) begin
                            rx_valid <= 1'b1;
                            rx_data  <= rx_next[8:1];
                            rx_perr  <= ^rx_next[9:1];
                            st       <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prog_link_master.sv
// Programming link master top: decodes byte-level commands, runs the open
// sequence (reset low, line high, clock on, two breaks), and maps the
// shifter and clock generator onto the pins.
// Assumes the caller waits for cmd_ready; commands other than open and
// close are dropped while the link is closed.
module prog_link_master
    import plm_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int ENABLE_BREAKS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_data,
    output logic             cmd_ready,
    output logic             busy,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             parity_error,
    output logic             link_clk,
    output logic             link_clk_oe,
    output logic             data_out,
    output logic             data_oe,
    input  logic             data_in,
    output logic             tgt_rst_n,
    output logic             tgt_rst_oe
);
    localparam int BRK_W = $clog2(ENABLE_BREAKS + 1);

    logic                  link_on;
    logic [BRK_W-1:0]      brk_left;
    logic                  accept;
    logic                  start_tx;
    logic                  start_rx;
    logic [FRAME_BITS-1:0] tx_frame;
    logic                  sh_active;
    logic                  sh_released;
    logic                  tx_done;
    logic                  rise_tick;
    logic                  fall_tick;

    // Handshake and command decode.
    always_comb begin
        busy      = sh_active || (brk_left != '0);
        cmd_ready = !busy;
        accept    = cmd_valid && cmd_ready;
        start_rx  = accept && link_on && (cmd_op == OP_RECV);
        start_tx  = (accept && (cmd_op == OP_ENABLE))
                 || (accept && link_on && ((cmd_op == OP_SEND) || (cmd_op == OP_BREAK)))
                 || (tx_done && (brk_left != '0));
        tx_frame  = (accept && (cmd_op == OP_SEND)) ? build_frame(cmd_data) : '1;
    end

    // Link open state and count of pending wake-up breaks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_on  <= 1'b0;
            brk_left <= '0;
        end else if (accept && (cmd_op == OP_ENABLE)) begin
            link_on  <= 1'b1;
            brk_left <= BRK_W'(ENABLE_BREAKS - 1);
        end else if (accept && (cmd_op == OP_DISABLE)) begin
            link_on  <= 1'b0;
            brk_left <= '0;
        end else if (tx_done && (brk_left != '0)) begin
            brk_left <= brk_left - BRK_W'(1);
        end
    end

    plm_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (link_on),
        .half_div  (half_div),
        .sclk      (link_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    plm_shifter u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .start_tx  (start_tx),
        .tx_frame  (tx_frame),
        .start_rx  (start_rx),
        .sdi       (data_in),
        .sdo       (data_out),
        .released  (sh_released),
        .active    (sh_active),
        .tx_done   (tx_done),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_perr   (parity_error)
    );

    // Pin enables follow the open state; reset is held low while open.
    always_comb begin
        link_clk_oe = link_on;
        data_oe     = link_on && !sh_released;
        tgt_rst_oe  = link_on;
        tgt_rst_n   = !link_on;
    end
endmodule

// File: rtl/plm_checker.sv
// Timing properties of the programming link master, bound to its top.
module plm_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] half_div,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_ready,
    input logic             busy,
    input logic             rx_valid,
    input logic             link_clk,
    input logic             link_clk_oe,
    input logic             data_out,
    input logic             data_oe
);
    // R3: a driven data line changes only together with a falling clock.
    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe) && (data_out != $past(data_out)))
        |-> (!link_clk && $past(link_clk)));

    // R8: the line is released while a received byte is reported.
    p_rx_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !data_oe);

    // R8: an open link releases the line only for an accepted receive.
    p_release_on_recv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(data_oe) && link_clk_oe)
        |-> $past(cmd_valid && cmd_ready && (cmd_op == 3'd1)));

    // R9: a closed link lets the clock rest low.
    p_clk_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_clk_oe |=> !link_clk);

    // R10: an accepted send blocks further commands.
    p_send_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 3'd0) && link_clk_oe)
        |=> (busy && !cmd_ready));

    // R12: with a divider above one, no level lasts a single cycle.
    p_half_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (link_clk_oe && (half_div > DIV_W'(1)) && (link_clk != $past(link_clk)))
        |=> (!link_clk_oe || (link_clk == $past(link_clk))));
endmodule

bind prog_link_master plm_checker #(.DIV_W(DIV_W)) u_plm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_div    (half_div),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_ready   (cmd_ready),
    .busy        (busy),
    .rx_valid    (rx_valid),
    .link_clk    (link_clk),
    .link_clk_oe (link_clk_oe),
    .data_out    (data_out),
    .data_oe     (data_oe)
);

// File: tb/sim_prog_link_master.sv
module sim_prog_link_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] half_div = DIV_W'(1);
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [7:0]       cmd_data = 8'd0;
    logic             cmd_ready, busy, rx_valid, parity_error;
    logic [7:0]       rx_data;
    logic             link_clk, link_clk_oe, data_out, data_oe;
    logic             data_in = 1'b1;
    logic             tgt_rst_n, tgt_rst_oe;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    prog_link_master #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .busy(busy), .rx_valid(rx_valid),
        .rx_data(rx_data), .parity_error(parity_error),
        .link_clk(link_clk), .link_clk_oe(link_clk_oe),
        .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
        .tgt_rst_n(tgt_rst_n), .tgt_rst_oe(tgt_rst_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk = n_chk + 1;
            n_err = n_err + 1;
            $display("FAIL watchdog act=%0d exp=<190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input bit bad);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return {2'b11, 1'((ones % 2) ^ int'(bad)), d, 1'b0};
    endfunction

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic capture_tx(output logic [11:0] f, output bit oe_ok);
        oe_ok = 1'b1;
        f = '1;
        do begin
            @(posedge link_clk); #1;
        end while (data_out !== 1'b0);
        f[0] = 1'b0;
        for (int i = 1; i < 12; i++) begin
            @(posedge link_clk); #1;
            f[i] = data_out;
            if (!data_oe) oe_ok = 1'b0;
        end
    endtask

    task automatic drive_rx(input logic [7:0] d, input bit bad, input int idle_n);
        logic [11:0] bits;
        bits = exp_frame(d, bad);
        for (int i = 0; i < idle_n; i++) begin
            @(negedge link_clk); data_in = 1'b1;
        end
        for (int i = 0; i < 12; i++) begin
            @(negedge link_clk); data_in = bits[i];
        end
        @(negedge link_clk); data_in = 1'b1;
    endtask

    task automatic recv_one(input logic [7:0] d, input bit bad, input int idle_n);
        logic [7:0] got;
        logic       perr;
        bit         rel_ok;
        do_cmd(3'd1, 8'd0);
        rel_ok = !data_oe;
        fork
            drive_rx(d, bad, idle_n);
            begin
                do @(negedge clk); while (!rx_valid);
                got = rx_data; perr = parity_error;
            end
        join
        chk(rel_ok, "R8 line released during receive", int'(data_oe), 0);
        chk(got == d, "R4 R5 received byte", int'(got), int'(d));
        chk(perr == bad, "R5 parity flag", int'(perr), int'(bad));
    endtask

    task automatic send_one(input logic [7:0] d);
        logic [11:0] f;
        bit          oe_ok;
        do_cmd(3'd0, d);
        capture_tx(f, oe_ok);
        chk(f == exp_frame(d, 1'b0), "R1 R2 sent frame", int'(f), int'(exp_frame(d, 1'b0)));
        chk(oe_ok, "R1 line driven during send", 0, 1);
    endtask

    task automatic measure_half(input logic [DIV_W-1:0] hd, input int expn);
        int n;
        do_cmd(3'd4, 8'd0);
        half_div = hd;
        do_cmd(3'd3, 8'd0);
        @(posedge link_clk);
        n = 0;
        @(negedge clk);
        while (link_clk) begin
            n++;
            @(negedge clk);
        end
        chk(n == expn, "R12 half period", n, expn);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state at the pins.
        chk(cmd_ready && !busy && !link_clk_oe && !data_oe && !tgt_rst_oe,
            "R13 reset state", {cmd_ready, busy, link_clk_oe, data_oe, tgt_rst_oe}, 5'b10000);

        // R11: send, receive and break while closed are dropped.
        do_cmd(3'd0, 8'h5A);
        do_cmd(3'd2, 8'd0);
        do_cmd(3'd1, 8'd0);
        repeat (30) @(negedge clk);
        chk(!data_oe && !link_clk_oe && !link_clk && !busy && !tgt_rst_oe,
            "R11 closed link ignores commands",
            {data_oe, link_clk_oe, link_clk, busy, tgt_rst_oe}, 0);

        // R7: open sequence.
        begin
            int  rises = 0;
            bit  all_high = 1'b1;
            logic prev;
            do_cmd(3'd3, 8'd0);
            chk(tgt_rst_oe && !tgt_rst_n && data_oe && data_out && link_clk_oe,
                "R7 open drives reset low and line high",
                {tgt_rst_oe, tgt_rst_n, data_oe, data_out, link_clk_oe}, 5'b10111);
            prev = link_clk;
            while (1) begin
                @(negedge clk);
                if (link_clk && !prev) begin
                    rises++;
                    if (!(data_out && data_oe)) all_high = 1'b0;
                end
                prev = link_clk;
                if (!busy) break;
            end
            chk(rises >= 24 && all_high, "R7 wake-up idle bits", rises, 24);
        end

        // R6: explicit break.
        begin
            int  rises = 0;
            bit  all_high = 1'b1;
            logic prev;
            do_cmd(3'd2, 8'd0);
            prev = link_clk;
            while (busy) begin
                @(negedge clk);
                if (link_clk && !prev) begin
                    rises++;
                    if (!(data_out && data_oe)) all_high = 1'b0;
                end
                prev = link_clk;
            end
            chk(rises >= 12 && all_high, "R6 break idle bits", rises, 12);
        end

        // R1 R2: all byte values at the fastest divider.
        for (int b = 0; b < 256; b++) send_one(8'(b));

        // R10: a send in flight blocks commands.
        cmd_data = 8'hC3;
        do_cmd(3'd0, 8'hC3);
        @(negedge clk);
        chk(busy && !cmd_ready, "R10 busy blocks commands", {busy, cmd_ready}, 2'b10);
        while (busy) @(negedge clk);

        // R4 R5 R8: all bytes received, varying idle lead-in.
        for (int b = 0; b < 256; b++) recv_one(8'(b), 1'b0, (b % 5) + 1);
        // R5: wrong parity on a spread of values.
        for (int b = 0; b < 256; b += 17) recv_one(8'(b), 1'b1, 2);

        // R8: a send after receiving drives the line again.
        send_one(8'hA5);
        chk(data_oe, "R8 line driven again after send", int'(data_oe), 1);

        // R12: divider settings.
        measure_half(DIV_W'(3), 3);
        measure_half(DIV_W'(0), 1);
        measure_half(DIV_W'(3), 3);

        // R3: data changes only when the clock falls, at a slow divider.
        begin
            bit   ok = 1'b1;
            logic pd, pc;
            do_cmd(3'd0, 8'h96);
            pd = data_out; pc = link_clk;
            while (busy) begin
                @(negedge clk);
                if (data_out != pd && !(pc && !link_clk)) ok = 1'b0;
                pd = data_out; pc = link_clk;
            end
            chk(ok, "R3 data changes on falling edge", 0, 1);
        end
        send_one(8'h3C);
        send_one(8'hFF);

        // R9: close releases everything and the clock rests low.
        do_cmd(3'd4, 8'd0);
        repeat (20) @(negedge clk);
        chk(!link_clk_oe && !data_oe && !tgt_rst_oe && !link_clk,
            "R9 close releases lines", {link_clk_oe, data_oe, tgt_rst_oe, link_clk}, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule